// File: doc/BRIEF.md
# Teletext Bit Request Controller

This block asks an external teletext source for a serial bitstream during chosen video lines and captures the bits it returns. It runs on the 27 MHz line-locked pixel clock. It follows the raster through a field-start pulse and a line-start pulse from the timing generator. On each selected line it opens an insertion window at a programmable pixel position. A fractional accumulator then spaces bit slots at the teletext bit rate.

Two handshakes are available toward the source. In the first, the request pin gives a one-cycle pulse for every bit, and the source answers after a programmable number of clocks. In the second, the request pin goes high once and stays high for the whole window while the source streams its bits. The window length depends on the selected teletext standard and includes the clock run-in bits. Captured bits go to the downstream insertion stage on a valid/ready port, and the final bit of each window is marked.

The output port has a single register stage. Once a bit is held, it stays stable until the stage accepts it. A bit captured while the held bit is still stalled is discarded, because the incoming stream cannot wait.

Top module: `txt_req_ctrl`

## Requirements
- R1: After reset, `txt_req` and `out_valid` are low. The active standard is code 0, the field flag is clear, and the line number is 0.
- R2: A clock edge with `field_start` high sets the line number to 1. Any other edge with `line_start` high adds one to the line number. An edge with `line_start` high sets the pixel position to 0, and every other edge adds one to it, saturating at its maximum. A window opens at an edge where all four of these hold: `enable` is high, no window is open, the line number lies in the current field's range, and the position equals `win_start`. The handshake mode and the delay are latched at that edge.
- R3: While a window is open, every edge adds NUM to an accumulator that starts at 0. When the sum reaches DEN, DEN is subtracted and that edge is a bit slot. NUM/DEN is 37/144 for standard code 0 (PAL WST). It is 7/33 for codes 1 (NTSC WST), 2 (NABTS) and 3. The window closes at the edge of its last slot. A window has 360 slots for code 0, 296 slots for code 1, and 288 slots for codes 2 and 3.
- R4: In per-bit mode (`req_mode`=0), `txt_req` is high for exactly the one cycle after each slot edge.
- R5: In gated mode (`req_mode`=1), `txt_req` rises after the opening edge, stays high, and falls after the closing edge.
- R6: For each slot, `txt_in` is sampled at the edge that comes L+1 edges after the slot edge, where L is the latched delay (0 to 15). The sample for the window's final slot carries `out_last`=1.
- R7: A capture loads `out_data` and `out_last` and raises `out_valid`, unless `out_valid` is high and `out_ready` is low at that edge. In that case the new bit is discarded and the held bit stays unchanged. An edge with no capture and with `out_ready` high clears `out_valid`.
- R8: An edge with `enable` low closes any open window, drives `txt_req` low after that edge, and cancels all pending captures.
- R9: `std_sel` is taken into the active standard only at an edge with `field_start` high. A change in the middle of a field has no effect until the next field.
- R10: Lines are chosen separately for each field. When `field_second`=0 was latched at field start, the window opens only for line numbers in [`fa_first`,`fa_last`]. When `field_second`=1 was latched, it opens only for line numbers in [`fb_first`,`fb_last`]. Outside these lines `txt_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz line-locked pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and idles |
| req_mode | input | 1 | 0 = per-bit pulse handshake, 1 = gated window |
| std_sel | input | 2 | Teletext standard code (0 PAL WST, 1 NTSC WST, 2 NABTS) |
| bit_delay | input | 4 | Source latency in clocks for the capture point |
| win_start | input | 11 | Pixel position at which the window opens |
| fa_first | input | 10 | First text line in the first field |
| fa_last | input | 10 | Last text line in the first field |
| fb_first | input | 10 | First text line in the second field |
| fb_last | input | 10 | Last text line in the second field |
| field_start | input | 1 | Pulse with the first line start of a field |
| field_second | input | 1 | Field identity, sampled on `field_start` |
| line_start | input | 1 | Pulse at the first clock of each line |
| txt_req | output | 1 | Request toward the teletext source |
| txt_in | input | 1 | Serial bitstream from the source |
| out_valid | output | 1 | Captured bit available |
| out_ready | input | 1 | Downstream accepts the held bit |
| out_data | output | 1 | Captured bit |
| out_last | output | 1 | Held bit is the window's last |

## Verification
Every result settles one edge after its cause. The line number, position and active standard change one edge after the timing pulses. `txt_req` changes one edge after an opening, slot or closing edge. `out_valid`, `out_data` and `out_last` change at the edge that comes L+1 edges after the slot. The bench drives inputs and compares every output on the falling edge, against a behavioural model that is updated on the rising edge. The model keeps its pending captures in a queue of due cycle numbers, so each comparison falls in the cycle the requirements name. Per-line counts of request rises and of gated high cycles are checked at the end of each line against values computed from the accumulator arithmetic. These checks cover window length, line and field selection, and the timing of a standard change.

// File: rtl/txt_pkg.sv
package txt_pkg;
  typedef enum logic [1:0] {
    STD_PAL_WST  = 2'd0,
    STD_NTSC_WST = 2'd1,
    STD_NABTS    = 2'd2,
    STD_SPARE    = 2'd3
  } txt_std_e;

  typedef enum logic {
    REQ_PER_BIT = 1'b0,
    REQ_GATED   = 1'b1
  } txt_proto_e;
endpackage

// File: rtl/txt_line_track.sv
module txt_line_track
  import txt_pkg::*;
#(
  parameter int LW = 10,
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          field_second,
  input  logic          line_start,
  input  logic [1:0]    std_sel,
  output logic [LW-1:0] line_no,
  output logic [PW-1:0] pos,
  output logic          fld2,
  output txt_std_e      std_act
);
  localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_no <= '0;
      fld2    <= 1'b0;
      std_act <= STD_PAL_WST;
    end else if (field_start) begin
      line_no <= LW'(1);
      fld2    <= field_second;
      std_act <= txt_std_e'(std_sel);
    end else if (line_start) begin
      line_no <= line_no + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pos <= '0;
    else if (line_start)      pos <= '0;
    else if (pos != POS_MAX)  pos <= pos + PW'(1);
  end
endmodule

// File: rtl/txt_bit_rate.sv
module txt_bit_rate #(
  parameter int ACC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [ACC_W-1:0] num,
  input  logic [ACC_W-1:0] den,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, num};
  assign tick = run && (sum >= {1'b0, den});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (run)   acc_q <= tick ? ACC_W'(sum - {1'b0, den}) : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/txt_win_ctrl.sv
module txt_win_ctrl
  import txt_pkg::*;
#(
  parameter int LW        = 10,
  parameter int PW        = 11,
  parameter int LAT_W     = 4,
  parameter int ACC_W     = 9,
  parameter int LEN_W     = 9,
  parameter int PAL_NUM   = 37,
  parameter int PAL_DEN   = 144,
  parameter int NTSC_NUM  = 7,
  parameter int NTSC_DEN  = 33,
  parameter int LEN_PAL   = 360,
  parameter int LEN_NTSC  = 296,
  parameter int LEN_NABTS = 288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  txt_proto_e       proto,
  input  logic [LAT_W-1:0] delay,
  input  logic [PW-1:0]    win_start,
  input  logic [LW-1:0]    rng_first [2],
  input  logic [LW-1:0]    rng_last  [2],
  input  logic [LW-1:0]    line_no,
  input  logic [PW-1:0]    pos,
  input  logic             fld2,
  input  txt_std_e         std_act,
  output logic             busy,
  output logic             tick,
  output logic             tick_last,
  output logic             req,
  output txt_proto_e       mode_q,
  output logic [LAT_W-1:0] lat_q
);
  logic [1:0]       in_rng;
  logic             line_hit;
  logic             open_go;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] len_sel;
  logic [ACC_W-1:0] num_sel;
  logic [ACC_W-1:0] den_sel;

  for (genvar f = 0; f < 2; f++) begin : g_fld
    assign in_rng[f] = (line_no >= rng_first[f]) && (line_no <= rng_last[f]);
  end

  assign line_hit = in_rng[fld2];
  assign open_go  = enable && !busy && line_hit && (pos == win_start);

  always_comb begin
    unique case (std_act)
      STD_PAL_WST: begin
        num_sel = ACC_W'(PAL_NUM);
        den_sel = ACC_W'(PAL_DEN);
        len_sel = LEN_W'(LEN_PAL);
      end
      STD_NTSC_WST: begin
        num_sel = ACC_W'(NTSC_NUM);
        den_sel = ACC_W'(NTSC_DEN);
        len_sel = LEN_W'(LEN_NTSC);
      end
      default: begin
        num_sel = ACC_W'(NTSC_NUM);
        den_sel = ACC_W'(NTSC_DEN);
        len_sel = LEN_W'(LEN_NABTS);
      end
    endcase
  end

  txt_bit_rate #(.ACC_W(ACC_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (open_go),
    .run   (busy && enable),
    .num   (num_sel),
    .den   (den_sel),
    .tick  (tick)
  );

  assign tick_last = tick && (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      req    <= 1'b0;
      left_q <= '0;
      mode_q <= REQ_PER_BIT;
      lat_q  <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
      req  <= 1'b0;
    end else if (open_go) begin
      busy   <= 1'b1;
      left_q <= len_sel;
      mode_q <= proto;
      lat_q  <= delay;
      req    <= (proto == REQ_GATED);
    end else if (busy && tick) begin
      left_q <= left_q - LEN_W'(1);
      if (tick_last) busy <= 1'b0;
      req <= (mode_q == REQ_PER_BIT) ? 1'b1 : !tick_last;
    end else begin
      req <= (mode_q == REQ_GATED) && busy;
    end
  end
endmodule

// File: rtl/txt_capture.sv
module txt_capture #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             tick,
  input  logic             tick_last,
  input  logic [LAT_W-1:0] lat,
  input  logic             txt_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_data,
  output logic             out_last
);
  localparam int DEPTH = 1 << LAT_W;

  logic [DEPTH-1:0] pend_q;
  logic [DEPTH-1:0] tag_q;
  logic             cap;
  logic             stall;

  assign cap   = !flush && pend_q[lat];
  assign stall = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tag_q  <= '0;
    end else if (flush) begin
      pend_q <= '0;
      tag_q  <= '0;
    end else begin
      pend_q <= {pend_q[DEPTH-2:0], tick};
      tag_q  <= {tag_q[DEPTH-2:0], tick_last};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_last  <= 1'b0;
    end else if (cap) begin
      if (!stall) begin
        out_valid <= 1'b1;
        out_data  <= txt_in;
        out_last  <= tag_q[lat];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txt_req_ctrl.sv
module txt_req_ctrl
  import txt_pkg::*;
#(
  parameter int LW        = 10,
  parameter int PW        = 11,
  parameter int LAT_W     = 4,
  parameter int PAL_NUM   = 37,
  parameter int PAL_DEN   = 144,
  parameter int NTSC_NUM  = 7,
  parameter int NTSC_DEN  = 33,
  parameter int LEN_PAL   = 360,
  parameter int LEN_NTSC  = 296,
  parameter int LEN_NABTS = 288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req_mode,
  input  logic [1:0]       std_sel,
  input  logic [LAT_W-1:0] bit_delay,
  input  logic [PW-1:0]    win_start,
  input  logic [LW-1:0]    fa_first,
  input  logic [LW-1:0]    fa_last,
  input  logic [LW-1:0]    fb_first,
  input  logic [LW-1:0]    fb_last,
  input  logic             field_start,
  input  logic             field_second,
  input  logic             line_start,
  output logic             txt_req,
  input  logic             txt_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_data,
  output logic             out_last
);
  localparam int DEN_MAX = (PAL_DEN > NTSC_DEN) ? PAL_DEN : NTSC_DEN;
  localparam int ACC_W   = $clog2(2 * DEN_MAX + 1);
  localparam int LEN_MAX = (LEN_PAL > LEN_NTSC) ?
                           ((LEN_PAL > LEN_NABTS) ? LEN_PAL : LEN_NABTS) :
                           ((LEN_NTSC > LEN_NABTS) ? LEN_NTSC : LEN_NABTS);
  localparam int LEN_W   = $clog2(LEN_MAX + 1);

  logic [LW-1:0]    line_no;
  logic [PW-1:0]    pos;
  logic             fld2;
  txt_std_e         std_act;
  logic [LW-1:0]    rng_first [2];
  logic [LW-1:0]    rng_last  [2];
  logic             busy;
  logic             tick;
  logic             tick_last;
  txt_proto_e       mode_q;
  logic [LAT_W-1:0] lat_q;

  assign rng_first[0] = fa_first;
  assign rng_last[0]  = fa_last;
  assign rng_first[1] = fb_first;
  assign rng_last[1]  = fb_last;

  txt_line_track #(.LW(LW), .PW(PW)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_start  (field_start),
    .field_second (field_second),
    .line_start   (line_start),
    .std_sel      (std_sel),
    .line_no      (line_no),
    .pos          (pos),
    .fld2         (fld2),
    .std_act      (std_act)
  );

  txt_win_ctrl #(
    .LW(LW), .PW(PW), .LAT_W(LAT_W), .ACC_W(ACC_W), .LEN_W(LEN_W),
    .PAL_NUM(PAL_NUM), .PAL_DEN(PAL_DEN),
    .NTSC_NUM(NTSC_NUM), .NTSC_DEN(NTSC_DEN),
    .LEN_PAL(LEN_PAL), .LEN_NTSC(LEN_NTSC), .LEN_NABTS(LEN_NABTS)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .proto     (txt_proto_e'(req_mode)),
    .delay     (bit_delay),
    .win_start (win_start),
    .rng_first (rng_first),
    .rng_last  (rng_last),
    .line_no   (line_no),
    .pos       (pos),
    .fld2      (fld2),
    .std_act   (std_act),
    .busy      (busy),
    .tick      (tick),
    .tick_last (tick_last),
    .req       (txt_req),
    .mode_q    (mode_q),
    .lat_q     (lat_q)
  );

  txt_capture #(.LAT_W(LAT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!enable),
    .tick      (tick),
    .tick_last (tick_last),
    .lat       (lat_q),
    .txt_in    (txt_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );
endmodule

// File: rtl/txt_req_ctrl_chk.sv
module txt_req_ctrl_chk #(
  parameter int MAX_BITS = 360
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       field_start,
  input logic       txt_req,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_data,
  input logic       out_last,
  input logic       mode_q,
  input logic       busy,
  input logic [1:0] std_act
);
  logic        req_d;
  logic [15:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      rises <= '0;
    end else begin
      req_d <= txt_req;
      rises <= !busy ? 16'd0 : rises + 16'(txt_req && !req_d);
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !txt_req); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && txt_req) |=> !txt_req); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= 16'(MAX_BITS)); // R3

  AST_STD_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(std_act)); // R9
endmodule

bind txt_req_ctrl txt_req_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .field_start (field_start),
  .txt_req     (txt_req),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_last    (out_last),
  .mode_q      (mode_q),
  .busy        (busy),
  .std_act     (std_act)
);

// File: tb/sim_txt_req_ctrl.sv
`timescale 1ns/1ps
module sim_txt_req_ctrl;
  localparam int LINE_LEN = 1600;
  localparam int WSTART   = 100;
  localparam int POS_MAX  = 2047;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, req_mode = 1'b0;
  logic [1:0] std_sel = 2'd0;
  logic [3:0] bit_delay = 4'd0;
  logic [10:0] win_start = 11'(WSTART);
  logic [9:0] fa_first = 10'd2, fa_last = 10'd3, fb_first = 10'd3, fb_last = 10'd4;
  logic       field_start = 1'b0, field_second = 1'b0, line_start = 1'b0;
  logic       txt_in = 1'b0, out_ready = 1'b1;
  logic       txt_req, out_valid, out_data, out_last;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  txt_req_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_mode(req_mode),
    .std_sel(std_sel), .bit_delay(bit_delay), .win_start(win_start),
    .fa_first(fa_first), .fa_last(fa_last), .fb_first(fb_first), .fb_last(fb_last),
    .field_start(field_start), .field_second(field_second), .line_start(line_start),
    .txt_req(txt_req), .txt_in(txt_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txt_in <= lfsr[3];
    out_ready <= stall_mode ? lfsr[7] : 1'b1;
  end

  function automatic int r_num(input int s); return (s == 0) ? 37 : 7; endfunction
  function automatic int r_den(input int s); return (s == 0) ? 144 : 33; endfunction
  function automatic int r_len(input int s);
    return (s == 0) ? 360 : (s == 1) ? 296 : 288;
  endfunction
  function automatic int gate_edges(input int s);
    int acc = 0, t = 0, e = 0;
    while (t < r_len(s)) begin
      e++; acc += r_num(s);
      if (acc >= r_den(s)) begin acc -= r_den(s); t++; end
    end
    return e;
  endfunction

  // behavioural reference
  int cyc, m_line, m_pos, m_fld2, m_std, m_acc, m_left, m_mode, m_lat;
  bit m_open, m_req, m_valid, m_data, m_last;
  int q_t[$];
  bit q_l[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_line = 0; m_pos = 0; m_fld2 = 0; m_std = 0; m_acc = 0;
      m_left = 0; m_mode = 0; m_lat = 0; m_open = 0; m_req = 0;
      m_valid = 0; m_data = 0; m_last = 0;
      q_t.delete(); q_l.delete();
    end else begin
      bit cap, lf, hit;
      cyc++;
      cap = 0; lf = 0;
      if (!enable) begin q_t.delete(); q_l.delete(); end
      else if (q_t.size() > 0 && q_t[0] == cyc) begin
        cap = 1; lf = q_l[0]; void'(q_t.pop_front()); void'(q_l.pop_front());
      end
      if (cap) begin
        if (!(m_valid && !out_ready)) begin m_valid = 1; m_data = txt_in; m_last = lf; end
      end else if (out_ready) m_valid = 0;

      hit = m_fld2 ? (m_line >= fb_first && m_line <= fb_last)
                   : (m_line >= fa_first && m_line <= fa_last);
      if (!enable) begin m_open = 0; m_req = 0; end
      else if (m_open) begin
        m_acc += r_num(m_std);
        if (m_acc >= r_den(m_std)) begin
          m_acc -= r_den(m_std); m_left--;
          q_t.push_back(cyc + 1 + m_lat); q_l.push_back(m_left == 0);
          if (m_left == 0) m_open = 0;
          m_req = (m_mode == 0) ? 1'b1 : m_open;
        end else m_req = (m_mode == 1);
      end else if (hit && m_pos == int'(win_start)) begin
        m_open = 1; m_acc = 0; m_left = r_len(m_std);
        m_mode = req_mode; m_lat = bit_delay; m_req = req_mode;
      end else m_req = 0;

      if (field_start) begin m_line = 1; m_fld2 = field_second; m_std = std_sel; end
      else if (line_start) m_line++;
      if (line_start) m_pos = 0; else if (m_pos < POS_MAX) m_pos++;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (txt_req !== m_req) begin
        n_fail++;
        $display("FAIL %s txt_req actual=%0b expected=%0b cycle=%0d",
                 !enable ? "R8" : (m_mode ? "R5" : "R4"), txt_req, m_req, cyc);
      end
      n_chk++;
      if (out_valid !== m_valid) begin
        n_fail++;
        $display("FAIL R7 out_valid actual=%0b expected=%0b cycle=%0d", out_valid, m_valid, cyc);
      end
      if (m_valid) begin
        n_chk++;
        if (out_data !== m_data || out_last !== m_last) begin
          n_fail++;
          $display("FAIL R6 data/last actual=%0b/%0b expected=%0b/%0b cycle=%0d",
                   out_data, out_last, m_data, m_last, cyc);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int b_line = 0, b_fld2 = 0, b_std = 0;

  task automatic run_line(input bit fs, input bit sec, input int abort_at, input string tag);
    int rises = 0, highs = 0;
    bit prev = 0, on, mode;
    @(negedge clk);
    line_start = 1; field_start = fs;
    if (fs) begin field_second = sec; b_line = 1; b_fld2 = sec; b_std = std_sel; end
    else b_line++;
    on   = enable && (b_fld2 ? (b_line >= fb_first && b_line <= fb_last)
                             : (b_line >= fa_first && b_line <= fa_last));
    mode = req_mode;
    @(negedge clk);
    line_start = 0; field_start = 0;
    for (int i = 1; i < LINE_LEN; i++) begin
      @(negedge clk);
      if (abort_at == i) enable = 0;
      if (txt_req && !prev) rises++;
      if (txt_req) highs++;
      prev = txt_req;
    end
    if (abort_at == 0) begin
      if (!on) check(rises == 0, {tag, " R10 quiet line"}, rises, 0);
      else if (!mode) check(rises == r_len(b_std), {tag, " R3 per-bit count"}, rises, r_len(b_std));
      else begin
        check(rises == 1, {tag, " R5 gate rises"}, rises, 1);
        check(highs == gate_edges(b_std), {tag, " R3 gate length"}, highs, gate_edges(b_std));
      end
    end else check(!txt_req, {tag, " R8 aborted"}, txt_req, 0);
  endtask

  task automatic run_field(input bit sec, input int ab_line, input int ab_at, input string tag);
    for (int l = 0; l < 4; l++) begin
      if (l > ab_line && ab_line >= 0) enable = 1;
      run_line(l == 0, sec, (l == ab_line) ? ab_at : 0, tag);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(txt_req == 0, "R1 reset req", txt_req, 0);
    check(out_valid == 0, "R1 reset valid", out_valid, 0);

    enable = 1; req_mode = 0; std_sel = 0; bit_delay = 3;
    run_field(0, -1, 0, "S1 R2 R4");
    run_field(1, -1, 0, "S1 R10");

    req_mode = 1; std_sel = 1; bit_delay = 0;
    run_field(0, -1, 0, "S2 R5");
    run_field(1, -1, 0, "S2 R5");

    req_mode = 0; bit_delay = 7;
    run_line(1, 0, 0, "S3 R9");
    std_sel = 2;
    for (int l = 1; l < 4; l++) run_line(0, 0, 0, "S3 R9 old std");
    run_field(1, -1, 0, "S3 R9 new std");

    stall_mode = 1; bit_delay = 15;
    run_field(0, -1, 0, "S4 R6 R7");
    stall_mode = 0;

    req_mode = 1; std_sel = 0;
    run_field(1, 2, 700, "S5 R8");

    enable = 0;
    run_field(0, -1, 0, "S6 R8 disabled");
    finish_run();
  end
endmodule